// File: doc/BRIEF.md
# I2C Master Byte Command Engine

This block is the bus-owning side of an I2C link, worked one byte at a time by software through four small registers: a command queue, a byte buffer, an interrupt enable mask and an interrupt status word. A single command write can queue any mix of bus start, byte send, byte receive and bus stop. The engine runs the queued phases in a fixed order and then posts one combined result to the status word. The status word raises an interrupt through the enable mask.

The bit timing comes from an external tick. Each tick advances one quarter of an SCL period. The engine drives SCL and SDA as open-drain pull-down enables and reads back the real line levels. When it sends a 1 and reads a 0, another master has won the bus. The engine then drops everything it had queued and releases both lines. A send, receive or stop that is issued while the engine does not hold the bus is reported as abnormal and also flushes the queue.

Register addresses on `reg_addr`:
- 0: command.
- 1: byte buffer.
- 2: interrupt enable.
- 3: interrupt status.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset the status and enable words are zero, `irq` is low, neither line is pulled, the command queue reads empty and the bus-held flag is clear.
- R2: The command word is written at address 0 with these bits: bit 0 start, bit 1 send, bit 3 receive, bit 4 last-byte, bit 5 stop. Reading the command word returns the pending queue in the same bit positions, the bus-held flag at bit 16, the sensed SDA level at bit 17 and the sensed SCL level at bit 18.
- R3: A send phase shifts out buffer bits 7:0, MSB first, and then samples the acknowledge. A low acknowledge sets status bit 0 and a high one sets status bit 1. Start plus send in one write therefore issues a start condition followed by the address byte. Afterwards SCL is held low and bit 16 reads 1.
- R4: A receive phase shifts in 8 bits, MSB first, into byte buffer bits 15:8 and sets status bit 2. It answers the byte with ACK, or with NACK when the last-byte bit was queued with it.
- R5: The phases queued by one write always run in the order start, send, receive, stop, whatever combination of bits is written.
- R6: A stop phase produces a stop condition, releases both lines, clears bit 16 and sets status bit 4.
- R7: Status bits from all phases of one write reach the status word together, in the same cycle, only after the last queued phase has ended.
- R8: If the engine releases SDA for a 1 during a send and senses SDA low, it sets status bit 3, flushes the whole queue (including a queued stop), releases both lines and clears bit 16.
- R9: A send, receive or stop that is dispatched while the bus is not held sets status bit 5, flushes the queue and causes no line activity.
- R10: A command write made while the engine has phases pending or running is ignored.
- R11: Writing to the status word clears exactly the bits written as 1 and leaves the other bits set.
- R12: `irq` is the OR of the status bits ANDed with the enable bits. The enable word uses the status bit layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 byte buffer, 2 enable, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Read data for the register selected by `reg_addr` |
| scl_tick | input | 1 | One pulse per quarter SCL period |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural target on a wired-AND bus is driven with several command mixes:
- An address alone, which separates a matched address (ACK) from an unmatched one (NAK).
- Send plus stop in one write, which shows whether the status bits are posted together or one phase at a time.
- A one-write read with last-byte set, which shows that start, send, receive and stop run in order and that the byte is answered with NACK.
- A two-step read, which separates an acknowledged byte from the final NACKed byte.

Error cases include a jammed SDA line during a send of all ones, which must flush a queued stop. They also include a send issued on a free bus, a command written while busy, a partial status clear and several enable masks.

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_tick,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  localparam logic [1:0] A_CMD = 2'd0, A_BUF = 2'd1, A_IEN = 2'd2, A_STS = 2'd3;
  localparam int SB_ACK = 0, SB_NAK = 1, SB_RXD = 2, SB_ARB = 3, SB_STOP = 4, SB_ABN = 5;

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RX, S_STOP} st_t;

  st_t        st;
  logic [1:0] ph;
  logic [3:0] bc;
  logic [7:0] sh, txb, rxb;
  logic [5:0] sts, acc, ien;
  logic       q_start, q_tx, q_rx, q_last, q_stop, owned;

  logic qany, busy, cmd_ok, smp, ph_end, eng_idle;
  logic [5:0] clr, commit;

  assign qany     = q_start | q_tx | q_rx | q_stop;
  assign eng_idle = (st == S_IDLE);
  assign busy     = !eng_idle || qany;
  assign cmd_ok   = reg_wr && reg_addr == A_CMD && !busy;
  assign smp      = scl_tick && ph == 2'd2;
  assign ph_end   = scl_tick && ph == 2'd3;
  assign clr      = (reg_wr && reg_addr == A_STS) ? reg_wdata[5:0] : 6'd0;
  assign commit   = (eng_idle && !qany) ? acc : 6'd0;
  assign irq      = |(sts & ien);

  always_comb begin
    case (st)
      S_START: begin sda_oe = ph[1];                    scl_oe = (ph == 2'd3); end
      S_STOP:  begin sda_oe = !ph[1];                   scl_oe = (ph == 2'd0); end
      S_TX:    begin sda_oe = (bc == 4'd8) ? 1'b0 : !sh[7];  scl_oe = (ph == 2'd0) || (ph == 2'd3); end
      S_RX:    begin sda_oe = (bc == 4'd8) ? !q_last : 1'b0; scl_oe = (ph == 2'd0) || (ph == 2'd3); end
      default: begin sda_oe = 1'b0;                     scl_oe = owned; end
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = {13'd0, scl_in, sda_in, owned, 10'd0, q_stop, q_last, q_rx, 1'b0, q_tx, q_start};
      A_BUF:   reg_rdata = {16'd0, rxb, txb};
      A_IEN:   reg_rdata = {26'd0, ien};
      default: reg_rdata = {26'd0, sts};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bc <= '0; sh <= '0; txb <= '0; rxb <= '0;
      sts <= '0; acc <= '0; ien <= '0; owned <= 1'b0;
      q_start <= 1'b0; q_tx <= 1'b0; q_rx <= 1'b0; q_last <= 1'b0; q_stop <= 1'b0;
    end else begin
      if (scl_tick && !eng_idle) ph <= ph + 2'd1;
      sts <= (sts & ~clr) | commit;
      if (eng_idle && !qany) acc <= '0;
      if (reg_wr && reg_addr == A_BUF) txb <= reg_wdata;
      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[5:0];
      if (cmd_ok) begin
        q_start <= reg_wdata[0]; q_tx <= reg_wdata[1]; q_rx <= reg_wdata[3];
        q_last  <= reg_wdata[4]; q_stop <= reg_wdata[5];
      end
      case (st)
        S_IDLE: if (qany) begin
          ph <= '0; bc <= '0;
          if (q_start) st <= S_START;
          else if (!owned) begin
            acc[SB_ABN] <= 1'b1;
            q_tx <= 1'b0; q_rx <= 1'b0; q_last <= 1'b0; q_stop <= 1'b0;
          end
          else if (q_tx) begin st <= S_TX; sh <= txb; end
          else if (q_rx) st <= S_RX;
          else st <= S_STOP;
        end
        S_START: if (ph_end) begin st <= S_IDLE; q_start <= 1'b0; owned <= 1'b1; end
        S_TX: begin
          if (smp) begin
            if (bc != 4'd8) begin
              if (sh[7] && !sda_in) begin
                acc[SB_ARB] <= 1'b1; owned <= 1'b0; st <= S_IDLE;
                q_tx <= 1'b0; q_rx <= 1'b0; q_last <= 1'b0; q_stop <= 1'b0;
              end
            end else if (sda_in) acc[SB_NAK] <= 1'b1;
            else acc[SB_ACK] <= 1'b1;
          end
          if (ph_end) begin
            if (bc == 4'd8) begin st <= S_IDLE; q_tx <= 1'b0; end
            else begin bc <= bc + 4'd1; sh <= {sh[6:0], 1'b0}; end
          end
        end
        S_RX: begin
          if (smp && bc != 4'd8) sh <= {sh[6:0], sda_in};
          if (ph_end) begin
            if (bc == 4'd8) begin
              rxb <= sh; acc[SB_RXD] <= 1'b1; st <= S_IDLE; q_rx <= 1'b0; q_last <= 1'b0;
            end else bc <= bc + 4'd1;
          end
        end
        S_STOP: if (ph_end) begin
          acc[SB_STOP] <= 1'b1; owned <= 1'b0; q_stop <= 1'b0; q_last <= 1'b0; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       owned,
  input logic       eng_idle,
  input logic       busy,
  input logic       qany,
  input logic       q_start,
  input logic       cmd_wr,
  input logic       wr_start,
  input logic [5:0] sts
);
  AST_FREE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle && !owned |-> !scl_oe && !sda_oe); // R9
  AST_HELD_BUS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle && owned |-> scl_oe && !sda_oe); // R3
  AST_NO_EARLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    qany |=> ((sts & ~$past(sts)) == 6'd0)); // R7
  AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && wr_start && !q_start |=> !q_start); // R10
  AST_ERROR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[3]) || $rose(sts[5]) |-> !qany && !owned); // R8
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[4]) |-> !owned && !scl_oe); // R6
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts != 6'd0); // R12
endmodule

bind i2c_byte_engine i2c_byte_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .owned(owned), .eng_idle(eng_idle), .busy(busy), .qany(qany), .q_start(q_start),
  .cmd_wr(reg_wr && reg_addr == 2'd0), .wr_start(reg_wdata[0]), .sts(sts));

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;
  localparam int CLK_P = 10;
  localparam logic [6:0] TADDR = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [31:0] reg_rdata;
  logic scl_tick = 1'b0;
  logic scl_oe, sda_oe, irq;
  logic t_pull = 1'b0, jam = 1'b0;
  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | t_pull | jam);

  int checks = 0, errs = 0;
  logic [1:0] tcnt = 2'd0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) begin tcnt <= tcnt + 2'd1; scl_tick <= (tcnt == 2'd3); end

  i2c_byte_engine dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_tick(scl_tick), .scl_in(scl_l),
    .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  // behavioural target
  logic t_act = 0, t_adr = 0, t_rd = 0, t_match = 0, t_mack = 0;
  logic [7:0] t_sh = 0, t_data = 0, t_got = 0;
  int t_bc = 0, t_nwr = 0, t_nstop = 0;

  always @(negedge sda_l) if (scl_l === 1'b1) begin
    t_act = 1; t_bc = 0; t_adr = 1; t_rd = 0; t_pull = 0; t_match = 0;
  end
  always @(posedge sda_l) if (scl_l === 1'b1) begin
    t_act = 0; t_pull = 0; t_nstop = t_nstop + 1;
  end
  always @(posedge scl_l) if (t_act) begin
    if (t_bc < 8) t_sh = {t_sh[6:0], sda_l}; else t_mack = !sda_l;
    t_bc = t_bc + 1;
  end
  always @(negedge scl_l) if (t_act) begin
    if (t_bc == 8) begin
      if (t_adr) begin t_match = (t_sh[7:1] == TADDR); t_rd = t_sh[0]; t_pull = t_match; end
      else if (t_rd) t_pull = 0;
      else t_pull = 1;
    end else if (t_bc == 9) begin
      t_bc = 0;
      if (t_adr) begin
        t_adr = 0;
        if (!t_match) begin t_act = 0; t_pull = 0; end
        else if (t_rd) t_pull = !t_data[7];
        else t_pull = 0;
      end else if (t_rd) begin
        t_data = t_data + 8'd1;
        if (t_mack) t_pull = !t_data[7];
        else begin t_pull = 0; t_act = 0; end
      end else begin t_got = t_sh; t_nwr = t_nwr + 1; t_pull = 0; end
    end else if (t_rd && !t_adr) t_pull = !t_data[7 - t_bc];
    else t_pull = 0;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin errs++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask
  task automatic wait_sts(output logic [31:0] v);
    v = 0;
    for (int i = 0; i < 4000; i++) begin rd(2'd3, v); if (v != 0) break; end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd3, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 enable", v, 0);
    rd(2'd0, v); chk("R1/R2 command word", v, 32'h0006_0000);
    chk("R1 lines/irq", {29'd0, scl_oe, sda_oe, irq}, 0);
  endtask

  task automatic t_write;
    logic [31:0] v;
    wr(2'd2, 8'h3F); wr(2'd1, {TADDR, 1'b0}); wr(2'd0, 8'h03);
    wait_sts(v); chk("R3 address ack", v, 32'h01);
    rd(2'd0, v); chk("R3 bus held", v, 32'h0003_0000);
    chk("R12 irq set", {31'd0, irq}, 1);
    wr(2'd3, 8'h3F); rd(2'd3, v); chk("R11 clear all", v, 0);
    chk("R12 irq clear", {31'd0, irq}, 0);
    wr(2'd1, 8'hA5); wr(2'd0, 8'h22);
    wait_sts(v); chk("R7 combined ack+stop", v, 32'h11);
    chk("R3 byte sent", {24'd0, t_got}, 32'hA5);
    rd(2'd0, v); chk("R6 bus released", v, 32'h0006_0000);
    wr(2'd3, 8'h01); rd(2'd3, v); chk("R11 partial clear", v, 32'h10);
    wr(2'd3, 8'h10);
  endtask

  task automatic t_nak;
    logic [31:0] v;
    wr(2'd1, 8'hB0); wr(2'd0, 8'h03);
    wait_sts(v); chk("R3 address nak", v, 32'h02);
    wr(2'd3, 8'h3F); wr(2'd0, 8'h20);
    wait_sts(v); chk("R6 stop after nak", v, 32'h10);
    wr(2'd3, 8'h3F);
  endtask

  task automatic t_read_one;
    logic [31:0] v; int ns;
    ns = t_nstop; t_data = 8'h3C;
    wr(2'd1, {TADDR, 1'b1}); wr(2'd0, 8'h3B);
    wait_sts(v); chk("R5 full sequence status", v, 32'h15);
    rd(2'd1, v); chk("R4 received byte", {24'd0, v[15:8]}, 32'h3C);
    chk("R4 nack on last", {31'd0, t_mack}, 0);
    chk("R5 stop ran last", t_nstop - ns, 1);
    wr(2'd3, 8'h3F);
  endtask

  task automatic t_read_two;
    logic [31:0] v;
    t_data = 8'h61;
    wr(2'd1, {TADDR, 1'b1}); wr(2'd0, 8'h0B);
    wait_sts(v); chk("R4 first read status", v, 32'h05);
    rd(2'd1, v); chk("R4 first byte", {24'd0, v[15:8]}, 32'h61);
    chk("R4 ack mid-read", {31'd0, t_mack}, 1);
    wr(2'd3, 8'h3F); wr(2'd0, 8'h38);
    wait_sts(v); chk("R4 second read status", v, 32'h14);
    rd(2'd1, v); chk("R4 second byte", {24'd0, v[15:8]}, 32'h62);
    chk("R4 final nack", {31'd0, t_mack}, 0);
    wr(2'd3, 8'h3F);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    wr(2'd1, {TADDR, 1'b0}); wr(2'd0, 8'h03); wr(2'd0, 8'h20);
    wait_sts(v); chk("R10 stop not taken", v, 32'h01);
    rd(2'd0, v); chk("R10 queue empty, bus held", v, 32'h0003_0000);
    wr(2'd3, 8'h3F); wr(2'd0, 8'h20);
    wait_sts(v); chk("R6 stop", v, 32'h10);
    wr(2'd3, 8'h3F);
  endtask

  task automatic t_abnormal;
    logic [31:0] v; int nw;
    nw = t_nwr;
    wr(2'd0, 8'h2A);
    wait_sts(v); chk("R9 abnormal", v, 32'h20);
    rd(2'd0, v); chk("R9 flushed, lines free", v, 32'h0006_0000);
    chk("R9 no byte on bus", t_nwr - nw, 0);
  endtask

  task automatic t_mask;
    wr(2'd2, 8'h00); chk("R12 masked", {31'd0, irq}, 0);
    wr(2'd2, 8'h20); chk("R12 enabled bit", {31'd0, irq}, 1);
    wr(2'd2, 8'h1F); chk("R12 other bits", {31'd0, irq}, 0);
    wr(2'd3, 8'h3F); wr(2'd2, 8'h3F);
  endtask

  task automatic t_arb;
    logic [31:0] v;
    jam = 1'b1;
    wr(2'd1, 8'hFF); wr(2'd0, 8'h23);
    wait_sts(v); chk("R8 arbitration loss only", v, 32'h08);
    rd(2'd0, v); chk("R8 queue flushed, released", v, 32'h0004_0000);
    jam = 1'b0;
    wr(2'd3, 8'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_write; t_nak; t_read_one; t_read_two; t_busy; t_abnormal; t_mask; t_arb;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule